// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs the command, address and data phases of a NAND flash bus for three operations: reading a page, programming a page and erasing a block. A host pulses `start` with an operation code, a byte position (for an erase, a block number), a transfer length, a spare-area select and three geometry inputs: page size, 16-bit bus width and five-cycle addressing. The block then raises chip enable, waits for the device to be ready, and issues the command and address cycles. It moves data between the flash bus and a byte stream with valid/ready handshakes, waits on the ready/busy line, and pulses `done`.

Every bus cycle lasts one clock and is driven from registers. A strobe is `nf_we` for command, address and write data, or `nf_re` for read data. `nf_cle` and `nf_ale` mark the command and address cycles. The ready/busy line is watched by a timeout counter. If the line stays low for too long, the operation ends with `err` and chip enable is released.

Top module: `nand_seq`

## Requirements
- R1: When a non-empty operation starts, `nf_ce` goes high and no strobe occurs until `nf_rb` has been seen high. `nf_ce` is low in the cycle that `done` pulses.
- R2: Program (`op`=1) produces these strobes in order: command 0x80, the address bytes, one data cycle per word, and command 0x10. `done` is then given only after `nf_rb` is high.
- R3: Read (`op`=0) produces command 0x00, the address bytes and command 0x30. Each data word then waits for `nf_rb` high before its `nf_re` pulse, and the bytes are delivered in order on the `rd_*` stream.
- R4: The column address is sent as two bytes, low byte first. It is 0 when `spare`=0 and the page size (512 << `pg_sel`) when `spare`=1, and it is shifted right by one when `bus16`=1.
- R5: The row address is `pos` divided by the page size, sent low byte first. It takes two bytes, or three bytes when `five_cyc`=1.
- R6: With `bus16`=1, each data word carries two stream bytes, the earlier byte in bits 7:0. An odd length leaves bits 15:8 of the last written word at zero.
- R7: Erase (`op`=2) produces command 0x60, then three address bytes that are bits 7:0, 15:8 and 23:16 of `pos`×page size×64, then commands 0xD0 and 0x70. It then waits for `nf_rb` high. `len` is ignored.
- R8: A read or program with `len`=0 pulses `done` in the cycle after `start` is sampled, with no strobe and with `nf_ce` never high.
- R9: Each wait checks `nf_rb` once per cycle. If `nf_rb` is still low on check number `tmo_lim`+1, the operation ends with `done` and `err` high and `nf_ce` low. If `nf_rb` is high on that same check, the operation continues without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 0 read, 1 program, 2 erase |
| pos | input | POS_W | Byte position, or block number for erase |
| len | input | LEN_W | Transfer length in bytes |
| spare | input | 1 | Select the spare area column |
| pg_sel | input | 2 | Page size is 512 << pg_sel bytes |
| bus16 | input | 1 | 16-bit flash data bus |
| five_cyc | input | 1 | Send a third row byte |
| tmo_lim | input | TMO_W | Ready/busy timeout limit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| wr_valid | input | 1 | Program byte available |
| wr_data | input | 8 | Program byte |
| wr_ready | output | 1 | Program byte accepted |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte consumed |
| nf_ce | output | 1 | Chip enable, active high |
| nf_cle | output | 1 | Command cycle marker |
| nf_ale | output | 1 | Address cycle marker |
| nf_we | output | 1 | Write strobe |
| nf_re | output | 1 | Read strobe |
| nf_oe | output | 1 | Data bus drive enable |
| nf_dq_o | output | 16 | Data bus out |
| nf_dq_i | input | 16 | Data bus in |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The timeout expiring and the ready/busy line rising can fall on the same check of a wait. The rule is that a ready seen on that check wins. The bench provokes this after the erase status command. It drops `nf_rb` as that strobe appears, holds it low for exactly `tmo_lim` cycles, and then for one cycle more. The first run must finish without `err` and the second must end with `err`. A second overlap occurs in the data phases, where stalls from ready/busy meet the stream handshake. This is judged by checking that no read strobe appears while the line is held low after the read confirm command.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2} op_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_RCONF = 8'h30;
  localparam logic [7:0] CMD_DIN   = 8'h80;
  localparam logic [7:0] CMD_PROG  = 8'h10;
  localparam logic [7:0] CMD_ESET  = 8'h60;
  localparam logic [7:0] CMD_ECONF = 8'hD0;
  localparam logic [7:0] CMD_STAT  = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_RDY0, S_CMD1, S_ADDR, S_CMD2, S_CMD3, S_WFIN,
    S_WGET, S_WPUT, S_RWAIT, S_RGET, S_RLAT, S_ROUT, S_END
  } st_e;
endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int POS_W      = 32,
  parameter int PG_MIN_LOG = 9
) (
  input  logic [POS_W-1:0] pos,
  input  logic             erase,
  input  logic             spare,
  input  logic [1:0]       pg_sel,
  input  logic             bus16,
  input  logic             five,
  output logic [4:0][7:0]  abyte,
  output logic [2:0]       naddr
);
  logic [4:0]       sh;
  logic [15:0]      col;
  logic [POS_W-1:0] row;
  logic [POS_W-1:0] ebase;

  always_comb begin
    sh    = 5'(PG_MIN_LOG) + {3'b000, pg_sel};
    col   = spare ? (16'd1 << sh) : 16'd0;
    if (bus16) col = col >> 1;
    row   = pos >> sh;
    ebase = pos << (sh + 5'd6);
    if (erase) begin
      abyte = {8'h00, 8'h00, ebase[23:16], ebase[15:8], ebase[7:0]};
      naddr = 3'd3;
    end else begin
      abyte = {row[23:16], row[15:8], row[7:0], col[15:8], col[7:0]};
      naddr = five ? 3'd5 : 3'd4;
    end
  end
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rb,
  input  logic [TMO_W-1:0] lim,
  output logic             ok,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign ok     = run & rb;
  assign expire = run & ~rb & (cnt == lim);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int POS_W      = 32,
  parameter int LEN_W      = 16,
  parameter int TMO_W      = 16,
  parameter int PG_MIN_LOG = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  input  logic             spare,
  input  logic [1:0]       pg_sel,
  input  logic             bus16,
  input  logic             five_cyc,
  input  logic [TMO_W-1:0] tmo_lim,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             nf_ce,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we,
  output logic             nf_re,
  output logic             nf_oe,
  output logic [15:0]      nf_dq_o,
  input  logic [15:0]      nf_dq_i,
  input  logic             nf_rb
);
  st_e              st;
  op_e              op_r;
  logic             b16_r, bsel;
  logic [4:0][7:0]  ab_n, ab_r;
  logic [2:0]       na_n, na_r, aidx;
  logic [LEN_W-1:0] rem;
  logic [15:0]      wbuf, rbuf;
  logic [TMO_W-1:0] lim_r;
  logic             wait_run, rdy_ok, rdy_exp;

  nand_addr_gen #(.POS_W(POS_W), .PG_MIN_LOG(PG_MIN_LOG)) u_addr (
    .pos(pos), .erase(op == OP_ERASE), .spare(spare), .pg_sel(pg_sel),
    .bus16(bus16), .five(five_cyc), .abyte(ab_n), .naddr(na_n)
  );

  assign wait_run = (st == S_RDY0) || (st == S_WFIN) || (st == S_RWAIT);

  nand_rb_wait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst(rst), .run(wait_run), .rb(nf_rb), .lim(lim_r),
    .ok(rdy_ok), .expire(rdy_exp)
  );

  assign busy     = (st != S_IDLE);
  assign wr_ready = (st == S_WGET);
  assign rd_valid = (st == S_ROUT);
  assign rd_data  = bsel ? rbuf[15:8] : rbuf[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  op_r <= OP_READ;  b16_r <= 1'b0;  bsel <= 1'b0;
      ab_r <= '0;  na_r <= '0;  aidx <= '0;  rem <= '0;
      wbuf <= '0;  rbuf <= '0;  lim_r <= '0;
      nf_ce <= 1'b0;  nf_cle <= 1'b0;  nf_ale <= 1'b0;  nf_we <= 1'b0;
      nf_re <= 1'b0;  nf_oe <= 1'b0;  nf_dq_o <= '0;
      done <= 1'b0;  err <= 1'b0;
    end else begin
      nf_cle <= 1'b0;  nf_ale <= 1'b0;  nf_we <= 1'b0;  nf_re <= 1'b0;
      nf_oe <= 1'b0;  done <= 1'b0;  err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_r <= op_e'(op);  b16_r <= bus16;  ab_r <= ab_n;  na_r <= na_n;
          rem <= len;  lim_r <= tmo_lim;
          if (op != OP_ERASE && len == '0) done <= 1'b1;
          else begin nf_ce <= 1'b1; st <= S_RDY0; end
        end
        S_RDY0, S_WFIN, S_RWAIT: begin
          if (rdy_ok) begin
            if (st == S_RDY0)      st <= S_CMD1;
            else if (st == S_WFIN) st <= S_END;
            else                   st <= S_RGET;
          end else if (rdy_exp) begin
            nf_ce <= 1'b0;  err <= 1'b1;  done <= 1'b1;  st <= S_IDLE;
          end
        end
        S_CMD1: begin
          nf_cle <= 1'b1;  nf_we <= 1'b1;  nf_oe <= 1'b1;
          nf_dq_o <= {8'h00, (op_r == OP_PROG) ? CMD_DIN :
                             (op_r == OP_ERASE) ? CMD_ESET : CMD_READ};
          aidx <= '0;  st <= S_ADDR;
        end
        S_ADDR: begin
          nf_ale <= 1'b1;  nf_we <= 1'b1;  nf_oe <= 1'b1;
          nf_dq_o <= {8'h00, ab_r[aidx]};
          aidx <= aidx + 1'b1;  bsel <= 1'b0;
          if (aidx == na_r - 1'b1) st <= (op_r == OP_PROG) ? S_WGET : S_CMD2;
        end
        S_WGET: if (wr_valid) begin
          rem <= rem - 1'b1;
          if (!b16_r) begin
            wbuf <= {8'h00, wr_data};  st <= S_WPUT;
          end else if (!bsel) begin
            wbuf <= {8'h00, wr_data};
            if (rem == 1) st <= S_WPUT;
            else          bsel <= 1'b1;
          end else begin
            wbuf[15:8] <= wr_data;  bsel <= 1'b0;  st <= S_WPUT;
          end
        end
        S_WPUT: begin
          nf_we <= 1'b1;  nf_oe <= 1'b1;  nf_dq_o <= wbuf;
          st <= (rem == '0) ? S_CMD2 : S_WGET;
        end
        S_CMD2: begin
          nf_cle <= 1'b1;  nf_we <= 1'b1;  nf_oe <= 1'b1;
          case (op_r)
            OP_PROG:  begin nf_dq_o <= {8'h00, CMD_PROG};  st <= S_WFIN;  end
            OP_ERASE: begin nf_dq_o <= {8'h00, CMD_ECONF}; st <= S_CMD3;  end
            default:  begin nf_dq_o <= {8'h00, CMD_RCONF}; st <= S_RWAIT; end
          endcase
        end
        S_CMD3: begin
          nf_cle <= 1'b1;  nf_we <= 1'b1;  nf_oe <= 1'b1;
          nf_dq_o <= {8'h00, CMD_STAT};  st <= S_WFIN;
        end
        S_RGET: begin nf_re <= 1'b1;  st <= S_RLAT; end
        S_RLAT: begin rbuf <= nf_dq_i;  bsel <= 1'b0;  st <= S_ROUT; end
        S_ROUT: if (rd_ready) begin
          rem <= rem - 1'b1;
          if (rem == 1)             st <= S_END;
          else if (b16_r && !bsel) bsel <= 1'b1;
          else                      st <= S_RWAIT;
        end
        S_END: begin nf_ce <= 1'b0;  done <= 1'b1;  st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       op,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             nf_ce,
  input logic             nf_cle,
  input logic             nf_ale,
  input logic             nf_we,
  input logic             nf_re,
  input logic             nf_oe,
  input logic             nf_rb
);
  assert_strobe_needs_ce_R1: assert property (@(posedge clk) disable iff (rst)
    (nf_we || nf_re) |-> nf_ce);
  assert_done_releases_ce_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !nf_ce);
  assert_cle_ale_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));
  assert_write_drives_bus_R2: assert property (@(posedge clk) disable iff (rst)
    nf_we |-> nf_oe);
  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(nf_we && nf_re));
  assert_read_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(nf_re) |-> $past(nf_rb, 2));
  assert_empty_completes_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && len == '0 && op != 2'd2) |=> (done && !nf_ce && !err));
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !nf_ce));
endmodule

bind nand_seq nand_seq_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_nand_seq.sv
module sim_nand_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] pos = '0;
  logic [15:0] len = '0;
  logic        spare = 1'b0, bus16 = 1'b0, five_cyc = 1'b0;
  logic [1:0]  pg_sel = '0;
  logic [15:0] tmo_lim = 16'd100;
  logic        busy, done, err, wr_ready, rd_valid;
  logic [7:0]  wr_data, rd_data;
  logic        nf_ce, nf_cle, nf_ale, nf_we, nf_re, nf_oe;
  logic [15:0] nf_dq_o, nf_dq_i;
  logic        nf_rb = 1'b1;

  logic [7:0]  src [64];
  logic [5:0]  sidx = '0;
  logic [7:0]  ridx = '0;
  logic [1:0]  lg_k [256];
  logic [15:0] lg_v [256];
  logic [7:0]  lg_n = '0;
  logic [7:0]  rc [256];
  logic [7:0]  rc_n = '0;

  assign wr_data = src[sidx];
  assign nf_dq_i = {ridx ^ 8'hA5, ridx + 8'h10};

  nand_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .pos(pos), .len(len),
    .spare(spare), .pg_sel(pg_sel), .bus16(bus16), .five_cyc(five_cyc),
    .tmo_lim(tmo_lim), .busy(busy), .done(done), .err(err),
    .wr_valid(1'b1), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(1'b1),
    .nf_ce(nf_ce), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we),
    .nf_re(nf_re), .nf_oe(nf_oe), .nf_dq_o(nf_dq_o), .nf_dq_i(nf_dq_i),
    .nf_rb(nf_rb)
  );

  // flash-side model: logs write strobes, advances read data, sinks/sources stream
  always @(posedge clk) begin
    if (nf_we) begin
      lg_k[lg_n] <= {nf_cle, nf_ale};
      lg_v[lg_n] <= nf_dq_o;
      lg_n <= lg_n + 8'd1;
    end
    if (nf_re) ridx <= ridx + 8'd1;
    if (wr_ready) sidx <= sidx + 6'd1;
    if (rd_valid) begin
      rc[rc_n] <= rd_data;
      rc_n <= rc_n + 8'd1;
    end
  end

  int total = 0, fails = 0;
  int run_cyc;
  logic run_err;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // kind: 2 command, 1 address, 0 data
  task automatic chk_log(input int idx, input logic [1:0] k, input logic [15:0] v,
                         input string req);
    chk(lg_k[idx[7:0]] == k && lg_v[idx[7:0]] == v, req,
        {14'd0, lg_k[idx[7:0]], lg_v[idx[7:0]]}, {14'd0, k, v});
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] p, input logic [15:0] l,
                        input logic sp, input logic [1:0] ps, input logic b, input logic f,
                        input logic [15:0] lim);
    op = o; pos = p; len = l; spare = sp; pg_sel = ps; bus16 = b; five_cyc = f;
    tmo_lim = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_cyc = 1;
    while (!done && run_cyc < 5000) begin
      @(negedge clk);
      run_cyc++;
    end
    run_err = err;
  endtask

  task automatic wait_cmd(input logic [7:0] code);
    do @(negedge clk); while (!(nf_we && nf_cle && nf_dq_o[7:0] == code));
  endtask

  task automatic t_reset;
    chk(!nf_ce && !busy && !done, "R1 reset idle", {nf_ce, busy, done}, 0);
    chk(!nf_we && !nf_re, "R1 reset strobes", {nf_we, nf_re}, 0);
  endtask

  task automatic t_prog8;
    int b = lg_n;
    src[sidx] = 8'h11; src[sidx + 6'd1] = 8'h22;
    src[sidx + 6'd2] = 8'h33; src[sidx + 6'd3] = 8'h44;
    nf_rb = 1'b0;
    fork
      run_op(2'd1, 32'h0001_2345, 16'd4, 1'b0, 2'd2, 1'b0, 1'b0, 16'd100);
      begin
        repeat (5) @(negedge clk);
        chk(nf_ce && lg_n == b[7:0], "R1 ce up, no cmd before ready", lg_n - b[7:0], 0);
        nf_rb = 1'b1;
      end
    join
    chk(lg_n - b[7:0] == 8'd10 && !run_err, "R2 program strobe count", lg_n - b[7:0], 10);
    chk_log(b,     2'd2, 16'h0080, "R2 data-input cmd");
    chk_log(b + 1, 2'd1, 16'h0000, "R4 col lo main");
    chk_log(b + 2, 2'd1, 16'h0000, "R4 col hi main");
    chk_log(b + 3, 2'd1, 16'h0024, "R5 row lo");
    chk_log(b + 4, 2'd1, 16'h0000, "R5 row hi");
    chk_log(b + 5, 2'd0, 16'h0011, "R2 data 0");
    chk_log(b + 8, 2'd0, 16'h0044, "R2 data 3");
    chk_log(b + 9, 2'd2, 16'h0010, "R2 program cmd");
    chk(!nf_ce, "R1 ce released", nf_ce, 0);
  endtask

  task automatic t_prog16_odd;
    int b = lg_n;
    src[sidx] = 8'h11; src[sidx + 6'd1] = 8'h22; src[sidx + 6'd2] = 8'h33;
    run_op(2'd1, 32'h0000_0800, 16'd3, 1'b1, 2'd1, 1'b1, 1'b0, 16'd100);
    chk(lg_n - b[7:0] == 8'd8, "R6 word count", lg_n - b[7:0], 8);
    chk_log(b + 1, 2'd1, 16'h0000, "R4 col lo spare x16");
    chk_log(b + 2, 2'd1, 16'h0002, "R4 col hi spare x16");
    chk_log(b + 3, 2'd1, 16'h0002, "R5 row lo");
    chk_log(b + 5, 2'd0, 16'h2211, "R6 byte pair low first");
    chk_log(b + 6, 2'd0, 16'h0033, "R6 odd tail high zero");
    chk_log(b + 7, 2'd2, 16'h0010, "R2 program cmd x16");
  endtask

  task automatic t_read16;
    int b = lg_n;
    int rb0 = rc_n;
    logic [7:0] r0 = ridx;
    logic seen_re = 1'b0;
    fork
      run_op(2'd0, 32'h0003_0000, 16'd4, 1'b1, 2'd0, 1'b1, 1'b1, 16'd100);
      begin
        wait_cmd(8'h30);
        nf_rb = 1'b0;
        repeat (6) begin @(negedge clk); if (nf_re) seen_re = 1'b1; end
        nf_rb = 1'b1;
      end
    join
    chk(!seen_re, "R3 no read strobe while busy", seen_re, 0);
    chk(lg_n - b[7:0] == 8'd7 && !run_err, "R3 read strobe count", lg_n - b[7:0], 7);
    chk_log(b,     2'd2, 16'h0000, "R3 read cmd");
    chk_log(b + 1, 2'd1, 16'h0000, "R4 col lo");
    chk_log(b + 2, 2'd1, 16'h0001, "R4 col hi halved");
    chk_log(b + 3, 2'd1, 16'h0080, "R5 row byte 0");
    chk_log(b + 4, 2'd1, 16'h0001, "R5 row byte 1");
    chk_log(b + 5, 2'd1, 16'h0000, "R5 third row byte");
    chk_log(b + 6, 2'd2, 16'h0030, "R3 read confirm");
    chk(ridx - r0 == 8'd2, "R3 read word count", ridx - r0, 2);
    chk(rc[rb0[7:0]] == r0 + 8'h10, "R6 read byte 0 low half", rc[rb0[7:0]], r0 + 8'h10);
    chk(rc[rb0[7:0] + 8'd1] == (r0 ^ 8'hA5), "R6 read byte 1 high half",
        rc[rb0[7:0] + 8'd1], r0 ^ 8'hA5);
    chk(rc[rb0[7:0] + 8'd3] == ((r0 + 8'd1) ^ 8'hA5), "R3 read byte 3",
        rc[rb0[7:0] + 8'd3], (r0 + 8'd1) ^ 8'hA5);
  endtask

  task automatic t_erase;
    int b = lg_n;
    run_op(2'd2, 32'd5, 16'd0, 1'b0, 2'd1, 1'b0, 1'b1, 16'd100);
    chk(lg_n - b[7:0] == 8'd6 && !run_err, "R7 erase strobe count", lg_n - b[7:0], 6);
    chk_log(b,     2'd2, 16'h0060, "R7 erase setup");
    chk_log(b + 1, 2'd1, 16'h0000, "R7 addr byte 0");
    chk_log(b + 2, 2'd1, 16'h0000, "R7 addr byte 1");
    chk_log(b + 3, 2'd1, 16'h0005, "R7 addr byte 2");
    chk_log(b + 4, 2'd2, 16'h00D0, "R7 erase confirm");
    chk_log(b + 5, 2'd2, 16'h0070, "R7 status cmd");
  endtask

  task automatic t_zero;
    int b = lg_n;
    logic ce_seen = 1'b0;
    run_op(2'd0, 32'h1234, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd100);
    chk(run_cyc == 1 && !run_err, "R8 immediate done", run_cyc, 1);
    chk(lg_n == b[7:0] && !nf_ce && !busy, "R8 no bus activity", lg_n - b[7:0], 0);
    repeat (3) begin @(negedge clk); if (nf_ce) ce_seen = 1'b1; end
    chk(!ce_seen, "R8 ce stays low", ce_seen, 0);
  endtask

  task automatic t_timeout_first;
    int b = lg_n;
    nf_rb = 1'b0;
    run_op(2'd2, 32'd1, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd3);
    nf_rb = 1'b1;
    chk(run_err == 1'b1 && run_cyc == 5, "R9 timeout at first wait", run_cyc, 5);
    chk(lg_n == b[7:0] && !nf_ce, "R9 no commands, ce released", lg_n - b[7:0], 0);
  endtask

  task automatic t_timeout_edge(input int extra, input logic exp_err);
    fork
      run_op(2'd2, 32'd2, 16'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd4);
      begin
        wait_cmd(8'h70);
        nf_rb = 1'b0;
        repeat (4 + extra) @(negedge clk);
        nf_rb = 1'b1;
      end
    join
    chk(run_err == exp_err && !nf_ce, "R9 ready vs timeout same check", run_err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prog8();
    t_prog16_odd();
    t_read16();
    t_erase();
    t_zero();
    t_timeout_first();
    t_timeout_edge(0, 1'b0);
    t_timeout_edge(1, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule